// File: doc/BRIEF.md
# Display Link Write Target with Control-Byte Framing

This block is the receive side of a two-wire serial link (I2C, write direction only) that feeds a display controller. It oversamples the bus clock and data lines with the system clock, finds bus start and stop conditions, and checks the first byte of each transfer against a seven-bit target address. Six of the address bits are fixed by a parameter. The lowest address bit comes from a strap input. When the address matches and the transfer is a write, the block acknowledges by pulling the data line low through an open-drain enable.

After the address, the transfer is framed by control bytes. Each control byte carries a continue flag and a payload-kind flag. When the continue flag is set, exactly one payload byte follows and then a new control byte is expected. When it is clear, every remaining byte up to the next stop or start is payload of the kind that control byte selected. Each payload byte leaves the block as an 8-bit value with a one-cycle strobe and a flag that marks it as panel memory data or as a command. The display core downstream consumes this stream.

Top module: `panel_link_target`

## Requirements
- R1: A falling data line while the clock line is high is a START; a rising data line while the clock line is high is a STOP. Any START, including one repeated inside a transfer, restarts address matching on the next byte, and the acknowledge drive is released in the cycle after either condition.
- R2: The first byte after START is acknowledged only when its upper seven bits equal `011110` followed by `addrSel`, and its bit 0 (the transfer direction) is 0. With `addrSel`=0 this is byte 0x78; with `addrSel`=1 it is byte 0x7A.
- R3: An address that does not match, or a read request (bit 0 = 1), gets no acknowledge. After it, no byte is acknowledged and no strobe is issued until the next START.
- R4: An acknowledge holds `sdaDrvLow` high from the clock-low phase that follows a byte's eighth bit until the falling clock edge that ends the ninth bit. `sdaDrvLow` never rises while the clock line is high, and it is low during all data bits.
- R5: A control byte uses bit 7 as the continue flag and bit 6 as the payload-kind flag. With continue = 1, exactly one payload byte follows, and the byte after it is parsed as a control byte again.
- R6: With continue = 0, every following byte until STOP or START is payload of the kind that control byte selected.
- R7: `byteIsData` equals the payload-kind flag of the governing control byte: 1 means panel memory data and 0 means a command.
- R8: Each payload byte produces exactly one single-cycle `byteStrobe`, with `byteOut` equal to the byte, shifted in MSB first. Address and control bytes produce no strobe. Every byte after the address, control or payload, is acknowledged.
- R9: After reset, `sdaDrvLow` and `byteStrobe` are low, and the block ignores bus bytes until a START.
- R10: After a STOP, bytes clocked on the bus without a new START are neither acknowledged nor emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Strap that supplies the lowest target address bit |
| sdaDrvLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| byteOut | output | 8 | Last received payload byte |
| byteIsData | output | 1 | 1 = panel memory data, 0 = command |
| byteStrobe | output | 1 | One-cycle pulse when a payload byte is presented |

## Verification
A wrong parse state shows up at the ports by the next byte at the latest. A state stuck in pass-through mode emits control bytes as payload. A state stuck in control mode swallows payload. A missed idle state acknowledges foreign traffic, which the bus master sees during the ninth clock of that very byte. A bit counter that is off by one shifts the acknowledge window onto a data bit and also corrupts `byteOut`. The bench keeps a behavioural model of the framing and compares every strobe with it on every clock. It also compares each ninth-bit acknowledge with the model's prediction, so any wrong state is reported within one byte time.

// File: rtl/plink_pkg.sv
package plink_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_ONE,
    ST_STREAM
  } linkState_t;

  typedef struct packed {
    logic clrCnt;
    logic ackReq;
    logic emit;
    logic emitData;
  } ctlStrobes_t;
endpackage

// File: rtl/plink_datapath.sv
module plink_datapath
  import plink_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrobes_t       ctl,
  output logic              startCond,
  output logic              stopCond,
  output logic              byteDone,
  output logic [BYTE_W-1:0] fullByte,
  output logic              sdaDrvLow,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteIsData,
  output logic              byteStrobe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;
  logic inAck, ackWanted;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_sync_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclChain[SYNC_STAGES-1];
  assign sdaS = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign byteDone  = sclRise & ~inAck & (bitCnt == LAST_BIT);
  assign fullByte  = {shiftReg[BYTE_W-2:0], sdaS};

  // bit counter, shifter and acknowledge window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      ackWanted <= 1'b0;
      sdaDrvLow <= 1'b0;
    end else if (ctl.clrCnt) begin
      bitCnt    <= '0;
      inAck     <= 1'b0;
      ackWanted <= 1'b0;
      sdaDrvLow <= 1'b0;
    end else begin
      if (sclRise && !inAck && bitCnt < ACK_SLOT) begin
        shiftReg <= fullByte;
        bitCnt   <= bitCnt + 1'b1;
      end
      if (byteDone) ackWanted <= ctl.ackReq;
      if (sclFall && !inAck && bitCnt == ACK_SLOT) begin
        inAck     <= 1'b1;
        sdaDrvLow <= ackWanted;
      end else if (sclFall && inAck) begin
        inAck     <= 1'b0;
        sdaDrvLow <= 1'b0;
        bitCnt    <= '0;
      end
    end
  end

  // payload output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteOut    <= '0;
      byteIsData <= 1'b0;
      byteStrobe <= 1'b0;
    end else begin
      byteStrobe <= ctl.emit;
      if (ctl.emit) begin
        byteOut    <= fullByte;
        byteIsData <= ctl.emitData;
      end
    end
  end

  AST_ACK_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !sclS); // R4
  AST_ACK_FALLS_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDrvLow) |-> (!sclS || $past(startCond || stopCond))); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    byteStrobe |=> !byteStrobe); // R8
  AST_COND_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (startCond || stopCond) |=> !sdaDrvLow); // R1
endmodule

// File: rtl/plink_control.sv
module plink_control
  import plink_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b011110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrSel,
  input  logic              startCond,
  input  logic              stopCond,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] fullByte,
  output ctlStrobes_t       ctl
);
  localparam int CO_BIT = BYTE_W - 1;
  localparam int DC_BIT = BYTE_W - 2;

  linkState_t state, stateNext;
  logic dcFlag, dcNext;
  logic addrHit;

  assign addrHit = (fullByte[BYTE_W-1:1] == {ADDR_HI, addrSel}) && !fullByte[0];

  always_comb begin
    ctl          = '0;
    ctl.clrCnt   = startCond | stopCond;
    ctl.emitData = dcFlag;
    stateNext    = state;
    dcNext       = dcFlag;
    if (startCond) begin
      stateNext = ST_ADDR;
    end else if (stopCond) begin
      stateNext = ST_IDLE;
    end else if (byteDone) begin
      unique case (state)
        ST_ADDR: begin
          ctl.ackReq = addrHit;
          stateNext  = addrHit ? ST_CTRL : ST_IDLE;
        end
        ST_CTRL: begin
          ctl.ackReq = 1'b1;
          dcNext     = fullByte[DC_BIT];
          stateNext  = fullByte[CO_BIT] ? ST_ONE : ST_STREAM;
        end
        ST_ONE: begin
          ctl.ackReq = 1'b1;
          ctl.emit   = 1'b1;
          stateNext  = ST_CTRL;
        end
        ST_STREAM: begin
          ctl.ackReq = 1'b1;
          ctl.emit   = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      dcFlag <= 1'b0;
    end else begin
      state  <= stateNext;
      dcFlag <= dcNext;
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopCond && !startCond) |=> state == ST_IDLE); // R10
  AST_STREAM_FROM_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_STREAM) |-> $past(state == ST_CTRL)); // R6
  AST_ONE_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ONE && byteDone && !startCond && !stopCond) |=> state == ST_CTRL); // R5
  AST_EMIT_PAYLOAD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |-> (state == ST_ONE || state == ST_STREAM)); // R8
endmodule

// File: rtl/panel_link_target.sv
module panel_link_target
  import plink_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b011110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  output logic       sdaDrvLow,
  output logic [7:0] byteOut,
  output logic       byteIsData,
  output logic       byteStrobe
);
  ctlStrobes_t ctl;
  logic startCond, stopCond, byteDone;
  logic [BYTE_W-1:0] fullByte;

  plink_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .startCond(startCond), .stopCond(stopCond), .byteDone(byteDone),
    .fullByte(fullByte), .sdaDrvLow(sdaDrvLow), .byteOut(byteOut),
    .byteIsData(byteIsData), .byteStrobe(byteStrobe)
  );

  plink_control #(.ADDR_HI(ADDR_HI)) u_ctl (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .startCond(startCond),
    .stopCond(stopCond), .byteDone(byteDone), .fullByte(fullByte), .ctl(ctl)
  );
endmodule

// File: tb/panel_link_target_test.sv
module panel_link_target_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaDrvLow, byteIsData, byteStrobe;
  logic [7:0] byteOut;
  logic sdaLine;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  // model: 0 idle, 1 address, 2 control, 3 single payload, 4 stream
  int mState = 0;
  bit mDc = 0;
  logic [8:0] expQ[$];

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDrvLow;

  panel_link_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaDrvLow(sdaDrvLow), .byteOut(byteOut), .byteIsData(byteIsData),
    .byteStrobe(byteStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobes compared with the model queue on every clock
  always @(negedge clk) begin
    if (rstN && byteStrobe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", {byteIsData, byteOut}, 0);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check({byteIsData, byteOut} == e, "R7 R8 payload byte/kind", {byteIsData, byteOut}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(6);
    sclM = 1'b1; tick(6);
    sdaM = 1'b0; tick(6);
    sclM = 1'b0; tick(2);
    mState = 1;
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(6);
    sclM = 1'b1; tick(6);
    sdaM = 1'b1; tick(8);
    mState = 0;
  endtask

  // model decides acknowledge and expected payload
  task automatic modelByte(input logic [7:0] b, output bit ack);
    ack = 0;
    case (mState)
      1: begin
        ack = (b[7:1] == {6'b011110, addrSel}) && !b[0];
        mState = ack ? 2 : 0;
      end
      2: begin ack = 1; mDc = b[6]; mState = b[7] ? 3 : 4; end
      3: begin ack = 1; expQ.push_back({mDc, b}); mState = 2; end
      4: begin ack = 1; expQ.push_back({mDc, b}); end
      default: ack = 0;
    endcase
  endtask

  task automatic sendByte(input logic [7:0] b, input string req);
    bit expAck;
    bit drvDuringData;
    modelByte(b, expAck);
    drvDuringData = 0;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(6);
      sclM = 1'b1; tick(4);
      if (sdaDrvLow) drvDuringData = 1;
      tick(4);
      sclM = 1'b0;
    end
    sdaM = 1'b1; tick(6);
    sclM = 1'b1; tick(5);
    check(sdaLine == !expAck, req, !sdaLine, expAck);
    tick(3);
    sclM = 1'b0; tick(6);
    check(!drvDuringData && !sdaDrvLow, "R4 no drive outside ack bit", drvDuringData, 0);
  endtask

  initial begin
    tick(5);
    check(!sdaDrvLow && !byteStrobe, "R9 reset outputs", {sdaDrvLow, byteStrobe}, 0);
    rstN = 1'b1;
    tick(5);
    check(!sdaDrvLow && !byteStrobe, "R9 idle after reset", {sdaDrvLow, byteStrobe}, 0);

    // mixed framing, strap 0
    busStart();
    sendByte(8'h78, "R2 address ack strap0");
    sendByte(8'h80, "R5 control co=1 cmd");
    sendByte(8'hAE, "R5 single command");
    sendByte(8'hC0, "R5 control co=1 data");
    sendByte(8'h55, "R7 single data");
    sendByte(8'h40, "R6 control co=0 data");
    sendByte(8'h01, "R6 stream 1");
    sendByte(8'h80, "R6 stream looks like control");
    sendByte(8'h03, "R6 stream 3");
    busStop();
    tick(4);
    check(expQ.size() == 0, "R6 all payload delivered", expQ.size(), 0);

    // wrong address
    busStart();
    sendByte(8'h7A, "R3 mismatch nack");
    sendByte(8'h00, "R3 ignored after mismatch");
    sendByte(8'h11, "R3 ignored after mismatch");
    busStop();

    // read request
    busStart();
    sendByte(8'h79, "R3 read nack");
    sendByte(8'h40, "R3 ignored after read");
    busStop();

    // strap 1, command stream then repeated start
    addrSel = 1'b1;
    tick(4);
    busStart();
    sendByte(8'h78, "R2 strap1 rejects 0x78");
    busStart();
    sendByte(8'h7A, "R1 repeated start address ack");
    sendByte(8'h00, "R6 control co=0 cmd");
    sendByte(8'hA5, "R7 command stream");
    sendByte(8'hFF, "R7 command stream");
    busStart();
    sendByte(8'h7A, "R1 repeated start rematch");
    sendByte(8'hC0, "R5 control data");
    sendByte(8'h33, "R5 single data");
    sendByte(8'h40, "R5 control after single");
    sendByte(8'h44, "R6 stream");
    sendByte(8'h45, "R6 stream");
    busStop();
    tick(4);
    check(expQ.size() == 0, "R8 payload count", expQ.size(), 0);

    // bytes after stop without start
    sendByte(8'h7A, "R10 no ack after stop");
    sendByte(8'h40, "R10 no ack after stop");
    tick(10);
    check(!byteStrobe && expQ.size() == 0, "R10 nothing emitted", expQ.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule